// File: doc/BRIEF.md
# Deferred Condition Code Evaluator

This block keeps a compact record of the most recent flag-producing operation: a 4-bit operation kind, the source operand and the 32-bit result. It does not derive the N, Z, V and C flags when the operation runs. A consumer that needs the flags raises an evaluation request. The block then rebuilds the flags from the stored source and result, using a recovery rule chosen by the operation kind. Add, subtract, narrow compares, extended arithmetic, shifts and logical operations each have their own rule.

After an evaluation, the record is rewritten as an already-resolved flag vector, so a later request returns the same flags without running the arithmetic again. The extended add and subtract kinds serve multi-word arithmetic chains. For these kinds a zero flag that has been cleared stays cleared across the chain. An operation code outside the defined set is refused: the block raises an error pulse and keeps its record unchanged.

Top module: `ccf_eval_top`

## Requirements
- R1: After reset, `flags_vld_o` and `op_err_o` are low and `flags_o` is 4'b0100. The stored record is an already-resolved vector (kind 0) that holds 4'b0100, so a first request returns 4'b0100. The flag vector is laid out as {N,Z,V,C} in bits [3:0].
- R2: A request on `eval_req_i` in cycle t drives `flags_vld_o` high for exactly cycle t+1, with the new vector on `flags_o`. `flags_o` keeps its value until the next request.
- R3: Once evaluated, the record turns into kind 0 and holds the produced vector, so a repeated request returns the same vector.
- R4: Kind 0 (already resolved) outputs bits [3:0] of the stored result unchanged as {N,Z,V,C}.
- R5: Kind 1 (logical) sets Z when the result is zero. Otherwise it sets N equal to result bit 31. V and C are 0. N and Z are never both set by any kind other than 0.
- R6: Kind 2 (add) sets C when result < source (unsigned). It sets V from bit 31 of (src^res) & ~((res-src)^src).
- R7: Kind 3 (subtract) rebuilds the minuend m = res+src. It sets C when m < src (unsigned) and sets V from bit 31 of (m^res)&(m^src).
- R8: Kind 4 (byte compare) and kind 5 (word compare) apply the R7 rule to the low 8 and low 16 bits. N, Z, C and V are all taken at that width, and upper bits are ignored.
- R9: Kind 6 (extended add) sets C when res <= src and rebuilds with res-src-1. Kind 7 (extended subtract) rebuilds m = res+src+1 and sets C when m <= src. V follows the R6 and R7 forms. For both kinds Z is ANDed with the Z bit of the last produced vector.
- R10: Kind 8 (shift) takes N and Z from the result, sets C when the stored source is nonzero, and leaves V at 0.
- R11: A record strobe carrying a code of 9 to 15 raises `op_err_o` for one cycle in the next cycle and leaves the stored record unchanged.
- R12: When a legal record and a request arrive in the same cycle, the evaluation uses the old record and the new record is the one stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rec_valid_i | input | 1 | Record strobe |
| rec_op_i | input | 4 | Operation kind of the record |
| rec_src_i | input | 32 | Source operand |
| rec_res_i | input | 32 | Operation result |
| eval_req_i | input | 1 | Evaluation request |
| flags_vld_o | output | 1 | Flag vector valid, one cycle after the request |
| flags_o | output | 4 | Flag vector {N,Z,V,C} |
| op_err_o | output | 1 | Illegal operation code pulse |

## Verification
A corrupted record shows on `flags_o` one cycle after the next request. Even a single wrong kind code usually flips C or V, because each kind recovers carry differently. A stale Z bit in the last vector stays hidden until an extended-kind evaluation, so the bench chains extended operations directly after vectors with Z set and with Z clear. A record that is not converted after evaluation, or that is overwritten by an illegal code, is exposed by evaluating a record whose kind would produce a different vector.

// File: rtl/ccf_pkg.sv
package ccf_pkg;

    localparam int CCF_DW = 32;
    localparam int CCF_OPW = 4;

    typedef enum logic [CCF_OPW-1:0] {
        OP_RAW   = 4'd0,
        OP_LOGIC = 4'd1,
        OP_ADD   = 4'd2,
        OP_SUB   = 4'd3,
        OP_CMPB  = 4'd4,
        OP_CMPW  = 4'd5,
        OP_ADDX  = 4'd6,
        OP_SUBX  = 4'd7,
        OP_SHIFT = 4'd8
    } ccf_op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } ccf_flags_t;

    localparam ccf_flags_t CCF_RESET_FLAGS = '{n: 1'b0, z: 1'b1, v: 1'b0, c: 1'b0};

    function automatic logic op_is_legal(input logic [CCF_OPW-1:0] code);
        return code <= OP_SHIFT;
    endfunction

endpackage

// File: rtl/ccf_sub_unit.sv
module ccf_sub_unit
    import ccf_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] src_i,
    input  logic [W-1:0] res_i,
    output ccf_flags_t   flags_o
);
    logic [W-1:0] minuend;
    logic [W-1:0] ovf_vec;
    logic         zero;

    assign minuend = res_i + src_i;
    assign ovf_vec = (minuend ^ res_i) & (minuend ^ src_i);
    assign zero    = (res_i == '0);

    assign flags_o.z = zero;
    assign flags_o.n = !zero && res_i[W-1];
    assign flags_o.c = (minuend < src_i);
    assign flags_o.v = ovf_vec[W-1];

endmodule

// File: rtl/ccf_calc.sv
module ccf_calc
    import ccf_pkg::*;
#(
    parameter int DW = CCF_DW
) (
    input  ccf_op_e       op_i,
    input  logic [DW-1:0] src_i,
    input  logic [DW-1:0] res_i,
    input  logic          prev_z_i,
    output ccf_flags_t    flags_o
);
    localparam int HALF_W = DW / 2;
    localparam int BYTE_W = DW / 4;
    localparam int NSUB   = 3;

    ccf_flags_t   sub_f [NSUB];
    logic         z32;
    logic         n32;
    logic [DW-1:0] add_t, add_ov;
    logic [DW-1:0] adx_t, adx_ov;
    logic [DW-1:0] sbx_t, sbx_ov;

    for (genvar g = 0; g < NSUB; g++) begin : g_sub
        localparam int W = (g == 0) ? DW : ((g == 1) ? HALF_W : BYTE_W);
        ccf_sub_unit #(.W(W)) u_sub (
            .src_i   (src_i[W-1:0]),
            .res_i   (res_i[W-1:0]),
            .flags_o (sub_f[g])
        );
    end

    assign z32    = (res_i == '0);
    assign n32    = !z32 && res_i[DW-1];

    assign add_t  = res_i - src_i;
    assign add_ov = (src_i ^ res_i) & ~(add_t ^ src_i);
    assign adx_t  = res_i - src_i - 1'b1;
    assign adx_ov = (src_i ^ res_i) & ~(adx_t ^ src_i);
    assign sbx_t  = res_i + src_i + 1'b1;
    assign sbx_ov = (sbx_t ^ res_i) & (sbx_t ^ src_i);

    always_comb begin
        flags_o = '0;
        unique case (op_i)
            OP_RAW: flags_o = ccf_flags_t'(res_i[3:0]);
            OP_LOGIC: begin
                flags_o.n = n32;
                flags_o.z = z32;
            end
            OP_ADD: begin
                flags_o.n = n32;
                flags_o.z = z32;
                flags_o.c = (res_i < src_i);
                flags_o.v = add_ov[DW-1];
            end
            OP_SUB:  flags_o = sub_f[0];
            OP_CMPW: flags_o = sub_f[1];
            OP_CMPB: flags_o = sub_f[2];
            OP_ADDX: begin
                flags_o.n = n32;
                flags_o.z = z32 && prev_z_i;
                flags_o.c = (res_i <= src_i);
                flags_o.v = adx_ov[DW-1];
            end
            OP_SUBX: begin
                flags_o.n = n32;
                flags_o.z = z32 && prev_z_i;
                flags_o.c = (sbx_t <= src_i);
                flags_o.v = sbx_ov[DW-1];
            end
            OP_SHIFT: begin
                flags_o.n = n32;
                flags_o.z = z32;
                flags_o.c = (src_i != '0);
            end
            default: flags_o = '0;
        endcase
    end

endmodule

// File: rtl/ccf_store.sv
module ccf_store
    import ccf_pkg::*;
#(
    parameter int DW = CCF_DW
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                rec_valid_i,
    input  logic [CCF_OPW-1:0]  rec_op_i,
    input  logic [DW-1:0]       rec_src_i,
    input  logic [DW-1:0]       rec_res_i,
    input  logic                eval_req_i,
    input  ccf_flags_t          eval_flags_i,
    output ccf_op_e             op_o,
    output logic [DW-1:0]       src_o,
    output logic [DW-1:0]       res_o
);
    localparam int PAD_W = DW - $bits(ccf_flags_t);

    logic load;
    assign load = rec_valid_i && op_is_legal(rec_op_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            op_o  <= OP_RAW;
            src_o <= '0;
            res_o <= {{PAD_W{1'b0}}, CCF_RESET_FLAGS};
        end else if (load) begin
            op_o  <= ccf_op_e'(rec_op_i);
            src_o <= rec_src_i;
            res_o <= rec_res_i;
        end else if (eval_req_i) begin
            op_o  <= OP_RAW;
            src_o <= '0;
            res_o <= {{PAD_W{1'b0}}, eval_flags_i};
        end
    end

    assert_state_held_R11: assert property (@(posedge clk) disable iff (rst)
        (rec_valid_i && !op_is_legal(rec_op_i) && !eval_req_i)
        |=> ($stable(op_o) && $stable(src_o) && $stable(res_o)));

    assert_resolved_after_eval_R3: assert property (@(posedge clk) disable iff (rst)
        (eval_req_i && !load) |=> (op_o == OP_RAW));

    assert_new_record_wins_R12: assert property (@(posedge clk) disable iff (rst)
        (eval_req_i && load) |=> (op_o != OP_RAW || res_o == $past(rec_res_i)));

endmodule

// File: rtl/ccf_eval_top.sv
module ccf_eval_top
    import ccf_pkg::*;
#(
    parameter int DW = CCF_DW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rec_valid_i,
    input  logic [3:0]    rec_op_i,
    input  logic [DW-1:0] rec_src_i,
    input  logic [DW-1:0] rec_res_i,
    input  logic          eval_req_i,
    output logic          flags_vld_o,
    output logic [3:0]    flags_o,
    output logic          op_err_o
);
    ccf_op_e       st_op;
    logic [DW-1:0] st_src;
    logic [DW-1:0] st_res;
    ccf_flags_t    calc_f;
    ccf_flags_t    flags_q;
    logic          vld_q;
    logic          err_q;

    ccf_store #(.DW(DW)) u_store (
        .clk          (clk),
        .rst          (rst),
        .rec_valid_i  (rec_valid_i),
        .rec_op_i     (rec_op_i),
        .rec_src_i    (rec_src_i),
        .rec_res_i    (rec_res_i),
        .eval_req_i   (eval_req_i),
        .eval_flags_i (calc_f),
        .op_o         (st_op),
        .src_o        (st_src),
        .res_o        (st_res)
    );

    ccf_calc #(.DW(DW)) u_calc (
        .op_i     (st_op),
        .src_i    (st_src),
        .res_i    (st_res),
        .prev_z_i (flags_q.z),
        .flags_o  (calc_f)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= CCF_RESET_FLAGS;
            vld_q   <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            vld_q <= eval_req_i;
            err_q <= rec_valid_i && !op_is_legal(rec_op_i);
            if (eval_req_i) begin
                flags_q <= calc_f;
            end
        end
    end

    assign flags_vld_o = vld_q;
    assign flags_o     = flags_q;
    assign op_err_o    = err_q;

    assert_vld_follows_req_R2: assert property (@(posedge clk) disable iff (rst)
        eval_req_i |=> flags_vld_o);

    assert_vld_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        !eval_req_i |=> (!flags_vld_o && $stable(flags_o)));

    assert_err_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        (rec_valid_i && rec_op_i > 4'd8) |=> op_err_o);

    assert_err_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        !rec_valid_i |=> !op_err_o);

    assert_nz_exclusive_R5: assert property (@(posedge clk) disable iff (rst)
        (st_op != OP_RAW) |-> !(calc_f.n && calc_f.z));

    assert_logic_vc_clear_R5: assert property (@(posedge clk) disable iff (rst)
        (st_op == OP_LOGIC) |-> (!calc_f.v && !calc_f.c));

    assert_shift_v_clear_R10: assert property (@(posedge clk) disable iff (rst)
        (st_op == OP_SHIFT) |-> !calc_f.v);

endmodule

// File: tb/ccf_eval_top_tb_top.sv
module ccf_eval_top_tb_top;

    localparam logic [3:0] K_RAW = 4'd0, K_LOG = 4'd1, K_ADD = 4'd2, K_SUB = 4'd3,
                           K_CMB = 4'd4, K_CMW = 4'd5, K_ADX = 4'd6, K_SBX = 4'd7,
                           K_SHF = 4'd8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rec_valid_i = 1'b0;
    logic [3:0]  rec_op_i = '0;
    logic [31:0] rec_src_i = '0;
    logic [31:0] rec_res_i = '0;
    logic        eval_req_i = 1'b0;
    logic        flags_vld_o;
    logic [3:0]  flags_o;
    logic        op_err_o;

    int n_vec = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    ccf_eval_top dut_i (
        .clk         (clk),
        .rst         (rst),
        .rec_valid_i (rec_valid_i),
        .rec_op_i    (rec_op_i),
        .rec_src_i   (rec_src_i),
        .rec_res_i   (rec_res_i),
        .eval_req_i  (eval_req_i),
        .flags_vld_o (flags_vld_o),
        .flags_o     (flags_o),
        .op_err_o    (op_err_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic record(input logic [3:0] op, input logic [31:0] src, input logic [31:0] res);
        @(negedge clk);
        rec_valid_i = 1'b1;
        rec_op_i    = op;
        rec_src_i   = src;
        rec_res_i   = res;
        @(negedge clk);
        rec_valid_i = 1'b0;
    endtask

    task automatic eval_chk(input string req, input logic [3:0] exp);
        @(negedge clk);
        eval_req_i = 1'b1;
        @(negedge clk);
        eval_req_i = 1'b0;
        chk({req, " valid"}, {31'b0, flags_vld_o}, 32'd1);
        chk(req, {28'b0, flags_o}, {28'b0, exp});
        @(negedge clk);
        chk({req, " valid drop"}, {31'b0, flags_vld_o}, 32'd0);
        chk({req, " hold"}, {28'b0, flags_o}, {28'b0, exp});
    endtask

    task automatic t_reset;
        chk("R1 vld", {31'b0, flags_vld_o}, 32'd0);
        chk("R1 err", {31'b0, op_err_o}, 32'd0);
        chk("R1 flags", {28'b0, flags_o}, 32'h4);
        eval_chk("R1 first eval", 4'b0100);
    endtask

    task automatic t_raw;
        record(K_RAW, 32'h0, 32'hFFFF_FFF9);
        eval_chk("R4 raw", 4'b1001);
        eval_chk("R3 re-eval", 4'b1001);
    endtask

    task automatic t_logic;
        record(K_LOG, 32'h5, 32'h8000_0000);
        eval_chk("R5 negative", 4'b1000);
        record(K_LOG, 32'hFFFF_FFFF, 32'h0);
        eval_chk("R5 zero", 4'b0100);
        record(K_LOG, 32'h0, 32'h0000_1234);
        eval_chk("R5 positive", 4'b0000);
    endtask

    task automatic t_add;
        record(K_ADD, 32'h1, 32'h0);
        eval_chk("R6 carry zero", 4'b0101);
        record(K_ADD, 32'h1, 32'h8000_0000);
        eval_chk("R6 overflow", 4'b1010);
    endtask

    task automatic t_sub;
        record(K_SUB, 32'h1, 32'hFFFF_FFFF);
        eval_chk("R7 borrow", 4'b1001);
        record(K_SUB, 32'h1, 32'h7FFF_FFFF);
        eval_chk("R7 overflow", 4'b0010);
    endtask

    task automatic t_cmp;
        record(K_CMB, 32'h0000_0001, 32'h1234_567F);
        eval_chk("R8 byte overflow", 4'b0010);
        record(K_CMW, 32'h0000_0005, 32'hABCD_0000);
        eval_chk("R8 word zero", 4'b0100);
        record(K_CMB, 32'hFFFF_FF02, 32'h0000_00FF);
        eval_chk("R8 byte borrow", 4'b1001);
    endtask

    task automatic t_ext;
        record(K_ADD, 32'h1, 32'h0);
        eval_chk("R9 chain start", 4'b0101);
        record(K_ADX, 32'h2, 32'h0);
        eval_chk("R9 addx z kept", 4'b0101);
        record(K_ADX, 32'h0, 32'h3);
        eval_chk("R9 addx nonzero", 4'b0000);
        record(K_ADX, 32'h0, 32'h0);
        eval_chk("R9 addx sticky clear z", 4'b0001);
        record(K_RAW, 32'h0, 32'h4);
        eval_chk("R9 set z", 4'b0100);
        record(K_SBX, 32'hFFFF_FFFF, 32'h0);
        eval_chk("R9 subx carry", 4'b0101);
        record(K_SBX, 32'h0, 32'h7FFF_FFFF);
        eval_chk("R9 subx overflow", 4'b0010);
    endtask

    task automatic t_shift;
        record(K_SHF, 32'h1, 32'h0);
        eval_chk("R10 out bit set", 4'b0101);
        record(K_SHF, 32'h0, 32'hC000_0000);
        eval_chk("R10 out bit clear", 4'b1000);
    endtask

    task automatic t_illegal;
        record(K_LOG, 32'h0, 32'h0);
        @(negedge clk);
        rec_valid_i = 1'b1;
        rec_op_i    = 4'd12;
        rec_res_i   = 32'h8000_0000;
        @(negedge clk);
        rec_valid_i = 1'b0;
        chk("R11 err pulse", {31'b0, op_err_o}, 32'd1);
        @(negedge clk);
        chk("R11 err single", {31'b0, op_err_o}, 32'd0);
        eval_chk("R11 record kept", 4'b0100);
    endtask

    task automatic t_overlap;
        record(K_LOG, 32'h0, 32'h8000_0000);
        eval_chk("R12 setup", 4'b1000);
        @(negedge clk);
        eval_req_i  = 1'b1;
        rec_valid_i = 1'b1;
        rec_op_i    = K_LOG;
        rec_res_i   = 32'h0;
        @(negedge clk);
        eval_req_i  = 1'b0;
        rec_valid_i = 1'b0;
        chk("R12 old record used", {28'b0, flags_o}, 32'h8);
        eval_chk("R12 new record stored", 4'b0100);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_raw();
        t_logic();
        t_add();
        t_sub();
        t_cmp();
        t_ext();
        t_shift();
        t_illegal();
        t_overlap();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(20 * 100000);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule